// File: doc/BRIEF.md
# Flash command interface state machine

This block is the command decoder and embedded-operation sequencer of a byte-wide parallel NOR flash. Host bus cycles (chip enable, write enable, output enable, address, data) arrive already synchronized to the internal clock. A write cycle takes its address when write enable falls and its data when write enable rises. Commands only take effect after a fixed two-write unlock prefix, so stray bus traffic cannot alter the array.

Three operations are supported: byte program, sector erase and whole-chip erase. A sector erase can be suspended and later resumed. While an operation runs, the ready/busy output is low, and reads return a status byte instead of array data. The array is a small internal register file. It has 2^SECT_W sectors of 2^OFS_W bytes each, and the sector is selected by the top address bits. Program and erase durations are cycle counts set by parameters.

Top module: `nor_cmd_fsm`

## Requirements
- R1: While `rst_n` is low the sequencer returns to read mode, any running operation is abandoned, `busy_n` is high, and the array keeps its contents. When no read is active (`ce_n` or `oe_n` high), `dout` is 00h.
- R2: A write cycle (with `ce_n` low) takes its address at the falling edge of `we_n` and its data at the rising edge. An address change between the two edges has no effect.
- R3: Byte program is four writes: AAh to unlock address A (55h, the low ADDR_W bits of 555h), 55h to unlock address B (AAh, the low bits of 2AAh), A0h to address A, and then the target address with its data. The stored byte becomes the old byte AND the data, so programming can only clear bits.
- R4: A write that does not match the expected step of a prefix (wrong address or data, including F0h) returns the decoder to read mode silently. Nothing is programmed and `busy_n` stays high.
- R5: `busy_n` goes low right after the final program write and stays low for about PGM_CYCLES clocks, until the byte is stored.
- R6: While a program runs, every write is ignored, including complete command sequences.
- R7: During an operation, a read returns a status byte. Bit 6 inverts at the start of every read. Bit 7 is the complement of bit 7 of the data being programmed, and is 0 during an erase. Bits 5..0 are 0.
- R8: Sector erase is six writes: AAh@A, 55h@B, 80h@A, AAh@A, 55h@B, then 30h at any address inside the target sector. The sector number is address bits [ADDR_W-1:OFS_W]. Every byte of that sector becomes FFh, and other sectors are unchanged.
- R9: Chip erase is the same prefix ending with 10h at address A. Every byte becomes FFh. No command is accepted while it runs.
- R10: Erase first pre-programs every byte of the region to 00h. It then times the pulse for ERS_CYCLES clocks, sets the bytes to FFh, and verifies them; any failed verify repeats the pulse.
- R11: During a sector erase, the only command accepted is B0h (suspend, any address), which is accepted in a single write. Once suspended, `busy_n` is high, reads return array data, and all writes except resume are ignored.
- R12: Writing 30h while suspended resumes the erase from where it stopped. `busy_n` goes low again and the erase completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| ce_n | input | 1 | Chip enable, active low, synchronized |
| we_n | input | 1 | Write enable, active low, synchronized |
| oe_n | input | 1 | Output enable, active low, synchronized |
| addr | input | ADDR_W | Byte address; the sector is in the top SECT_W bits |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status byte, 00h when not reading |
| busy_n | output | 1 | Low while a program or erase runs |

## Verification
The bench keeps the default geometry, SECT_W=6 and OFS_W=2, which gives 64 sectors of four bytes. It shortens the timing to PGM_CYCLES=40 and ERS_CYCLES=60. A program then lasts long enough for two status reads or a full ignored command sequence to fit inside it. A sector-erase pulse is long enough to suspend it after the pre-program walk, where the erasing sector reads back as 00h, and to apply a mid-program hardware reset. With four-byte sectors a whole-chip erase ends within a few hundred clocks, so every byte can be checked after it.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PGM_ARM,
        ST_ERS_ARM,
        ST_ERS_UNL1,
        ST_ERS_UNL2,
        ST_PGM_RUN,
        ST_ERS_PRE,
        ST_ERS_PULSE,
        ST_ERS_CLR,
        ST_ERS_VFY,
        ST_ERS_SUSP
    } fsm_e;

    localparam logic [7:0]  KEY_FIRST  = 8'hAA;
    localparam logic [7:0]  KEY_SECOND = 8'h55;
    localparam logic [7:0]  OP_PROGRAM = 8'hA0;
    localparam logic [7:0]  OP_ERASE   = 8'h80;
    localparam logic [7:0]  OP_CHIP    = 8'h10;
    localparam logic [7:0]  OP_SECTOR  = 8'h30;
    localparam logic [7:0]  OP_SUSPEND = 8'hB0;
    localparam logic [7:0]  OP_RESUME  = 8'h30;
    localparam logic [11:0] UNLOCK_A   = 12'h555;
    localparam logic [11:0] UNLOCK_B   = 12'h2AA;

endpackage

// File: rtl/nor_bus_cap.sv
module nor_bus_cap #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              rd_act,
    output logic              rd_stb
);
    typedef struct packed {
        logic              we;
        logic              rd;
        logic              stb;
        logic [ADDR_W-1:0] adr;
        logic [7:0]        dat;
    } cap_t;

    cap_t cap_d, cap_q;
    logic we_fall, we_rise;

    assign rd_act  = ~ce_n & ~oe_n;
    assign we_fall = ~ce_n & cap_q.we & ~we_n;
    assign we_rise = ~ce_n & ~cap_q.we & we_n;

    always_comb begin
        cap_d     = cap_q;
        cap_d.we  = we_n;
        cap_d.rd  = rd_act;
        cap_d.stb = we_rise;
        if (we_fall) cap_d.adr = addr;
        if (we_rise) cap_d.dat = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q    <= '0;
            cap_q.we <= 1'b1;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign wr_stb  = cap_q.stb;
    assign wr_addr = cap_q.adr;
    assign wr_data = cap_q.dat;
    assign rd_stb  = rd_act & ~cap_q.rd;

    // R2: the latched address is left alone at the rising edge of write enable
    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we_rise |=> $stable(cap_q.adr));

endmodule

// File: rtl/nor_array.sv
module nor_array #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [7:0]        rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [7:0]        rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
    import nor_cmd_pkg::*;
#(
    parameter int SECT_W     = 6,
    parameter int OFS_W      = 2,
    parameter int PGM_CYCLES = 40,
    parameter int ERS_CYCLES = 60,
    localparam int ADDR_W    = SECT_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              busy_n
);
    localparam int MAX_CYC = (PGM_CYCLES > ERS_CYCLES) ? PGM_CYCLES : ERS_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [ADDR_W-1:0] ADR_KEY_A = ADDR_W'(UNLOCK_A);
    localparam logic [ADDR_W-1:0] ADR_KEY_B = ADDR_W'(UNLOCK_B);
    localparam logic [CNT_W-1:0]  PGM_LOAD  = CNT_W'(PGM_CYCLES - 1);
    localparam logic [CNT_W-1:0]  ERS_LOAD  = CNT_W'(ERS_CYCLES - 1);

    typedef struct packed {
        fsm_e              st;
        fsm_e              resume;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] idx;
        logic [ADDR_W-1:0] tgt_addr;
        logic [7:0]        tgt_data;
        logic              chip;
        logic              tog;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              wr_stb, rd_act, rd_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_wa, rb_addr;
    logic [7:0]        mem_wd, rd_a, rd_b;
    logic              busy, ers_sector, last_byte, take_susp;
    logic [ADDR_W-1:0] region_start;

    nor_bus_cap #(.ADDR_W(ADDR_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .addr    (addr),
        .din     (din),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_act  (rd_act),
        .rd_stb  (rd_stb)
    );

    assign rb_addr = (ctl_q.st == ST_PGM_RUN) ? ctl_q.tgt_addr : ctl_q.idx;

    nor_array #(.ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_wa),
        .wdata   (mem_wd),
        .raddr_a (addr),
        .rdata_a (rd_a),
        .raddr_b (rb_addr),
        .rdata_b (rd_b)
    );

    always_comb begin
        unique case (ctl_q.st)
            ST_PGM_RUN, ST_ERS_PRE, ST_ERS_PULSE, ST_ERS_CLR, ST_ERS_VFY: busy = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    assign ers_sector   = busy && (ctl_q.st != ST_PGM_RUN) && !ctl_q.chip;
    assign last_byte    = ctl_q.chip ? (&ctl_q.idx) : (&ctl_q.idx[OFS_W-1:0]);
    assign region_start = ctl_q.chip ? '0 : {ctl_q.idx[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    assign take_susp    = ers_sector && wr_stb && (wr_data == OP_SUSPEND);

    always_comb begin
        ctl_d  = ctl_q;
        mem_we = 1'b0;
        mem_wa = ctl_q.idx;
        mem_wd = 8'h00;
        unique case (ctl_q.st)
            ST_READ: if (wr_stb)
                ctl_d.st = (wr_addr == ADR_KEY_A && wr_data == KEY_FIRST) ? ST_UNL1 : ST_READ;
            ST_UNL1: if (wr_stb)
                ctl_d.st = (wr_addr == ADR_KEY_B && wr_data == KEY_SECOND) ? ST_UNL2 : ST_READ;
            ST_UNL2: if (wr_stb) begin
                if (wr_addr == ADR_KEY_A && wr_data == OP_PROGRAM)    ctl_d.st = ST_PGM_ARM;
                else if (wr_addr == ADR_KEY_A && wr_data == OP_ERASE) ctl_d.st = ST_ERS_ARM;
                else                                                  ctl_d.st = ST_READ;
            end
            ST_PGM_ARM: if (wr_stb) begin
                ctl_d.tgt_addr = wr_addr;
                ctl_d.tgt_data = wr_data;
                ctl_d.cnt      = PGM_LOAD;
                ctl_d.st       = ST_PGM_RUN;
            end
            ST_ERS_ARM: if (wr_stb)
                ctl_d.st = (wr_addr == ADR_KEY_A && wr_data == KEY_FIRST) ? ST_ERS_UNL1 : ST_READ;
            ST_ERS_UNL1: if (wr_stb)
                ctl_d.st = (wr_addr == ADR_KEY_B && wr_data == KEY_SECOND) ? ST_ERS_UNL2 : ST_READ;
            ST_ERS_UNL2: if (wr_stb) begin
                if (wr_addr == ADR_KEY_A && wr_data == OP_CHIP) begin
                    ctl_d.chip = 1'b1;
                    ctl_d.idx  = '0;
                    ctl_d.st   = ST_ERS_PRE;
                end else if (wr_data == OP_SECTOR) begin
                    ctl_d.chip = 1'b0;
                    ctl_d.idx  = {wr_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
                    ctl_d.st   = ST_ERS_PRE;
                end else begin
                    ctl_d.st = ST_READ;
                end
            end
            ST_PGM_RUN: begin
                if (ctl_q.cnt == '0) begin
                    mem_we   = 1'b1;
                    mem_wa   = ctl_q.tgt_addr;
                    mem_wd   = rd_b & ctl_q.tgt_data;
                    ctl_d.st = ST_READ;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_ERS_PRE: begin
                mem_we = 1'b1;
                mem_wd = 8'h00;
                if (last_byte) begin
                    ctl_d.idx = region_start;
                    ctl_d.cnt = ERS_LOAD;
                    ctl_d.st  = ST_ERS_PULSE;
                end else begin
                    ctl_d.idx = ctl_q.idx + 1'b1;
                end
            end
            ST_ERS_PULSE: begin
                if (ctl_q.cnt == '0) ctl_d.st  = ST_ERS_CLR;
                else                 ctl_d.cnt = ctl_q.cnt - 1'b1;
            end
            ST_ERS_CLR: begin
                mem_we = 1'b1;
                mem_wd = 8'hFF;
                if (last_byte) begin
                    ctl_d.idx = region_start;
                    ctl_d.st  = ST_ERS_VFY;
                end else begin
                    ctl_d.idx = ctl_q.idx + 1'b1;
                end
            end
            ST_ERS_VFY: begin
                if (rd_b != 8'hFF) begin
                    ctl_d.idx = region_start;
                    ctl_d.cnt = ERS_LOAD;
                    ctl_d.st  = ST_ERS_PULSE;
                end else if (last_byte) begin
                    ctl_d.st = ST_READ;
                end else begin
                    ctl_d.idx = ctl_q.idx + 1'b1;
                end
            end
            ST_ERS_SUSP: if (wr_stb && wr_data == OP_RESUME)
                ctl_d.st = ctl_q.resume;
            default: ctl_d.st = ST_READ;
        endcase

        if (take_susp) begin
            ctl_d        = ctl_q;
            mem_we       = 1'b0;
            ctl_d.resume = ctl_q.st;
            ctl_d.st     = ST_ERS_SUSP;
        end

        if (rd_stb && busy) ctl_d.tog = ~ctl_q.tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q        <= '0;
            ctl_q.st     <= ST_READ;
            ctl_q.resume <= ST_READ;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    logic stat_dp;
    assign stat_dp = (ctl_q.st == ST_PGM_RUN) ? ~ctl_q.tgt_data[7] : 1'b0;
    assign dout    = !rd_act ? 8'h00 : (busy ? {stat_dp, ctl_q.tog, 6'b0} : rd_a);
    assign busy_n  = ~busy;

    // R1: the first clock after reset release finds read mode with ready high
    assert_reset_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctl_q.st == ST_READ) && busy_n);

    // R5: busy goes low right after the final program write
    assert_busy_after_pgm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_PGM_ARM && wr_stb) |=> !busy_n);

    // R6: writes during a program neither change the target nor start anything
    assert_pgm_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_PGM_RUN && wr_stb) |=>
            (ctl_q.st == ST_PGM_RUN || ctl_q.st == ST_READ) &&
            $stable(ctl_q.tgt_addr) && $stable(ctl_q.tgt_data));

    // R3: a program store never sets a bit that was clear
    assert_clear_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && ctl_q.st == ST_PGM_RUN) |-> ((mem_wd & ~rd_b) == 8'h00));

    // R7: every read that starts during an operation inverts the toggle bit
    assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !busy_n) |=> (ctl_q.tog != $past(ctl_q.tog)));

    // R11: while suspended, writes other than resume leave the suspension in place
    assert_susp_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ERS_SUSP && wr_stb && wr_data != OP_RESUME) |=>
            (ctl_q.st == ST_ERS_SUSP) && busy_n);

    // R9: a chip erase never enters suspension
    assert_chip_no_susp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_q.chip && ctl_q.st != ST_PGM_RUN) |=> (ctl_q.st != ST_ERS_SUSP));

endmodule

// File: tb/nor_cmd_fsm_tb.sv
`timescale 1ns/1ps
module nor_cmd_fsm_tb;
    localparam int SECT_W = 6;
    localparam int OFS_W  = 2;
    localparam int AW     = SECT_W + OFS_W;
    localparam int PGM_C  = 40;
    localparam int ERS_C  = 60;
    localparam logic [AW-1:0] KA = 8'h55;
    localparam logic [AW-1:0] KB = 8'hAA;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic busy_n;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    nor_cmd_fsm #(.SECT_W(SECT_W), .OFS_W(OFS_W), .PGM_CYCLES(PGM_C), .ERS_CYCLES(ERS_C)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .busy_n(busy_n)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            $display("FAIL watchdog: act=%0d exp<%0d cycles", cyc, 100000);
            checks = checks + 1;
            fails  = fails + 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write_skew(input logic [AW-1:0] a_fall, input logic [AW-1:0] a_rise,
                                  input logic [7:0] d);
        @(negedge clk); addr = a_fall; ce_n = 1'b0;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk); addr = a_rise; din = d;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        bus_write_skew(a, a, d);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        @(negedge clk); d = dout;
        @(negedge clk); oe_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 2000 && !busy_n; i++) @(negedge clk);
    endtask

    task automatic do_program(input logic [AW-1:0] a, input logic [7:0] d);
        bus_write(KA, 8'hAA); bus_write(KB, 8'h55); bus_write(KA, 8'hA0); bus_write(a, d);
    endtask

    task automatic erase_prefix();
        bus_write(KA, 8'hAA); bus_write(KB, 8'h55); bus_write(KA, 8'h80);
        bus_write(KA, 8'hAA); bus_write(KB, 8'h55);
    endtask

    task automatic expect_byte(input logic [AW-1:0] a, input logic [7:0] e, input string req);
        logic [7:0] v;
        bus_read(a, v);
        chk(v == e, req, v, e);
    endtask

    task automatic t_reset();
        idle(3);
        chk(busy_n == 1'b1, "R1 busy_n in reset", busy_n, 1);
        chk(dout == 8'h00, "R1 dout idle in reset", dout, 0);
        rst_n = 1'b1;
        idle(2);
        chk(busy_n == 1'b1, "R1 busy_n after reset", busy_n, 1);
    endtask

    task automatic t_chip_erase();
        int bad;
        logic [7:0] v;
        erase_prefix();
        bus_write(KA, 8'h10);
        chk(busy_n == 1'b0, "R9 busy_n low in chip erase", busy_n, 0);
        bus_read(8'h00, v);
        chk(v[7] == 1'b0 && v[5:0] == 6'h00, "R7 erase status bits", v, {1'b0, v[6], 6'h00});
        bus_write(8'h00, 8'hB0);
        chk(busy_n == 1'b0, "R9 suspend ignored in chip erase", busy_n, 0);
        wait_ready();
        bad = 0;
        for (int a = 0; a < (1 << AW); a++) begin
            bus_read(AW'(a), v);
            if (v != 8'hFF) bad++;
        end
        chk(bad == 0, "R9 all bytes FF after chip erase", bad, 0);
    endtask

    task automatic t_program_and();
        do_program(8'h30, 8'h5A);
        wait_ready();
        expect_byte(8'h30, 8'h5A, "R3 program byte");
        do_program(8'h30, 8'hF0);
        wait_ready();
        expect_byte(8'h30, 8'h50, "R3 program only clears bits");
    endtask

    task automatic t_busy_length();
        do_program(8'h31, 8'h00);
        chk(busy_n == 1'b0, "R5 busy low after final write", busy_n, 0);
        idle(PGM_C - 10);
        chk(busy_n == 1'b0, "R5 busy low near end", busy_n, 0);
        idle(12);
        chk(busy_n == 1'b1, "R5 ready after program", busy_n, 1);
    endtask

    task automatic t_status();
        logic [7:0] s1, s2;
        do_program(8'h10, 8'h80);
        bus_read(8'h10, s1);
        bus_read(8'h10, s2);
        chk(s1[6] != s2[6], "R7 toggle bit inverts", s2[6], ~s1[6]);
        chk(s1[7] == 1'b0 && s1[5:0] == 6'h00, "R7 inverted data bit", s1, {1'b0, s1[6], 6'h00});
        wait_ready();
        expect_byte(8'h10, 8'h80, "R7 array after status");
    endtask

    task automatic t_pgm_ignores();
        do_program(8'h04, 8'h3C);
        do_program(8'h08, 8'h00);
        wait_ready();
        expect_byte(8'h08, 8'hFF, "R6 command during program ignored");
        expect_byte(8'h04, 8'h3C, "R6 running program completes");
    endtask

    task automatic t_bad_prefix();
        bus_write(KA, 8'hAA); bus_write(KB, 8'h56); bus_write(KA, 8'hA0); bus_write(8'h28, 8'h00);
        chk(busy_n == 1'b1, "R4 wrong key starts nothing", busy_n, 1);
        expect_byte(8'h28, 8'hFF, "R4 wrong key no program");
        bus_write(KA, 8'hAA); bus_write(8'h00, 8'hF0);
        bus_write(KB, 8'h55); bus_write(KA, 8'hA0); bus_write(8'h2C, 8'h00);
        chk(busy_n == 1'b1, "R4 F0 in prefix starts nothing", busy_n, 1);
        expect_byte(8'h2C, 8'hFF, "R4 F0 in prefix no program");
    endtask

    task automatic t_addr_edge();
        bus_write(KA, 8'hAA); bus_write(KB, 8'h55); bus_write(KA, 8'hA0);
        bus_write_skew(8'h20, 8'h24, 8'h0F);
        wait_ready();
        expect_byte(8'h20, 8'h0F, "R2 address from falling edge");
        expect_byte(8'h24, 8'hFF, "R2 late address unused");
    endtask

    task automatic t_sector_suspend();
        logic [7:0] v;
        for (int i = 0; i < 4; i++) begin
            do_program(AW'(8'h18 + i), 8'h11);
            wait_ready();
        end
        do_program(8'h14, 8'h77);
        wait_ready();
        erase_prefix();
        bus_write(8'h19, 8'h30);
        idle(10);
        bus_write(8'h00, 8'hB0);
        chk(busy_n == 1'b1, "R11 ready while suspended", busy_n, 1);
        expect_byte(8'h14, 8'h77, "R11 read other sector while suspended");
        expect_byte(8'h18, 8'h00, "R10 sector pre-programmed to 00");
        bus_write(8'h00, 8'hA0);
        chk(busy_n == 1'b1, "R11 other write keeps suspension", busy_n, 1);
        bus_write(8'h00, 8'h30);
        chk(busy_n == 1'b0, "R12 busy after resume", busy_n, 0);
        wait_ready();
        for (int i = 0; i < 4; i++) begin
            bus_read(AW'(8'h18 + i), v);
            chk(v == 8'hFF, "R8 sector byte erased", v, 8'hFF);
        end
        expect_byte(8'h14, 8'h77, "R8 neighbour sector kept");
    endtask

    task automatic t_erase_ignores();
        erase_prefix();
        bus_write(8'h15, 8'h30);
        do_program(8'h1C, 8'h00);
        chk(busy_n == 1'b0, "R11 non-suspend write ignored in erase", busy_n, 0);
        wait_ready();
        expect_byte(8'h1C, 8'hFF, "R11 program during erase ignored");
        expect_byte(8'h14, 8'hFF, "R8 sector 5 erased");
    endtask

    task automatic t_hw_reset();
        do_program(8'h0C, 8'h00);
        idle(5);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(2);
        chk(busy_n == 1'b1, "R1 reset aborts program", busy_n, 1);
        expect_byte(8'h0C, 8'hFF, "R1 aborted byte unchanged");
        expect_byte(8'h30, 8'h50, "R1 array kept over reset");
    endtask

    initial begin
        t_reset();
        t_chip_erase();
        t_program_and();
        t_busy_length();
        t_status();
        t_pgm_ignores();
        t_bad_prefix();
        t_addr_edge();
        t_sector_suspend();
        t_erase_ignores();
        t_hw_reset();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule